// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as a small byte-wide serial EEPROM on a two-wire bus. The host drives the clock line and its own data level. The block samples both lines with the system clock and finds the start and stop conditions. It then takes in the device byte, any address bytes and the data bytes, one bit per clock rise with the most significant bit first. It answers through an open-drain style output, where 1 means the line is released and 0 means the line is pulled low. The level the host reads back is the AND of its own data level and the slave level.

The storage is an internal register array. The parameter `MEM_BYTES` (a power of two) sets its size. The size also fixes the addressing scheme:
- Below 256 bytes, the address is carried in the device byte itself.
- Below 4096 bytes, the device byte carries the upper address bits and one address byte follows.
- At 4096 bytes and above, a high address byte comes first and a low address byte follows it.

Sequential reads and writes step the address and wrap at the memory size.

Top module: `twi_eeprom`

## Requirements
- R1: A falling host data level while the clock is high (a start) begins reception of a new device byte. The bit count restarts at 8 and the slave line is released. This holds even in the middle of a byte.
- R2: A rising host data level while the clock is high (a stop) returns the block to idle with the slave line released. Clock pulses in idle are ignored: no acknowledge is given and no byte is stored.
- R3: In a receiving phase, each clock rise shifts one bit in, MSB first. After the eighth bit, the slave pulls its line low (0) from the next clock fall until the following clock fall, which is the acknowledge slot.
- R4: In a read, the slave presents the data byte MSB first, changing its output on each clock fall. After the eighth bit it also drives 0 in the acknowledge slot. In every other phase, the slave line is 1.
- R5: Bit 0 of the device byte selects the direction: 1 means read and 0 means write.
- R6: When `MEM_BYTES` < 256, device-byte bits 7:1 are the word address, for both reads and writes. Data bytes follow the device byte directly.
- R7: When 256 <= `MEM_BYTES` < 4096, a write's device-byte bits 3:1 become address bits 10:8, truncated to the memory size. The next byte supplies address bits 7:0.
- R8: When `MEM_BYTES` >= 4096, a write's device byte is followed by the high address byte and then the low address byte. The address is masked to the memory size.
- R9: After each data-byte acknowledge, the address steps by one, modulo `MEM_BYTES`. A read reloads the next byte from the new address. For larger memories, a read without address bytes starts from the current address, so a write header followed by a repeated start gives a random read.
- R10: `sdaBusOut` is the AND of `sdaHostIn` and `sdaSlaveOut`, and reads 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock from the host |
| sdaHostIn | input | 1 | Data level driven by the host |
| sdaSlaveOut | output | 1 | Slave data drive; 0 pulls low, 1 releases |
| sdaBusOut | output | 1 | Resolved data line (host AND slave) |

## Verification
Each bus line passes through two synchronizer flops and one previous-value flop before edges are seen. So `sdaSlaveOut` and the internal state change on the third rising clock edge after an input change, and `sdaBusOut` follows one delta later. The host tasks hold every bus phase for six system clocks and change inputs on falling edges. Acknowledge and read bits are sampled at the end of the clock-high phase, well after that three-cycle delay. Three instances, one per size class, are each driven by their own host lines. Their read data is compared with a reference array that the bench keeps from its own writes, with the wrap applied.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WR,
    ST_WR_ACK
  } busState_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic bitIn;       // synchronized host data level
    logic shiftIn;     // shift bitIn into the byte latch
    logic setAddrDev;  // take address bits from the device byte
    logic loadAddrHi;  // address <= received byte << 8
    logic orAddrLo;    // address |= received byte
    logic memWrite;    // store received byte at address
    logic incAddr;     // address + 1, wrapping
    logic loadRead;    // latch <= memory at next address
    logic drvLow;      // pull slave line low
    logic drvBit;      // present latch MSB and shift latch left
    logic relLine;     // release slave line
  } dpCtl_t;

endpackage

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES = 512
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      latchLsb,
  output dpCtl_t    ctl,
  output busState_e state,
  output logic [3:0] bitCnt
);

  localparam bit SMALL = (MEM_BYTES < 256);
  localparam bit MID   = !SMALL && (MEM_BYTES < 4096);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic sclRise, sclFall, startCond, stopCond;
  busState_e stateNext;
  logic [3:0] cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclSync[SYNC_STAGES-1];
  assign sdaNow    = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startCond = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopCond  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_comb begin
    stateNext = state;
    cntNext   = bitCnt;
    ctl       = '0;
    ctl.bitIn = sdaNow;
    if (startCond) begin
      stateNext   = ST_DEV;
      cntNext     = 4'd8;
      ctl.relLine = 1'b1;
    end else if (stopCond) begin
      stateNext   = ST_IDLE;
      ctl.relLine = 1'b1;
    end else if (sclRise) begin
      unique case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          ctl.shiftIn = 1'b1;
          cntNext     = bitCnt - 4'd1;
          if (bitCnt == 4'd1) begin
            unique case (state)
              ST_DEV: stateNext = ST_DEV_ACK;
              ST_AHI: begin
                ctl.loadAddrHi = 1'b1;
                stateNext      = ST_AHI_ACK;
              end
              ST_ALO: begin
                ctl.orAddrLo = 1'b1;
                stateNext    = ST_ALO_ACK;
              end
              default: begin
                ctl.memWrite = 1'b1;
                stateNext    = ST_WR_ACK;
              end
            endcase
          end
        end
        ST_DEV_ACK: begin
          cntNext = 4'd8;
          if (latchLsb) begin
            stateNext      = ST_RD;
            ctl.setAddrDev = SMALL;
            ctl.loadRead   = 1'b1;
          end else if (SMALL) begin
            ctl.setAddrDev = 1'b1;
            stateNext      = ST_WR;
          end else if (MID) begin
            ctl.setAddrDev = 1'b1;
            stateNext      = ST_ALO;
          end else begin
            stateNext = ST_AHI;
          end
        end
        ST_AHI_ACK: begin
          stateNext = ST_ALO;
          cntNext   = 4'd8;
        end
        ST_ALO_ACK: begin
          stateNext = ST_WR;
          cntNext   = 4'd8;
        end
        ST_RD: begin
          cntNext = bitCnt - 4'd1;
          if (bitCnt == 4'd1) stateNext = ST_RD_ACK;
        end
        ST_RD_ACK: begin
          stateNext    = ST_RD;
          cntNext      = 4'd8;
          ctl.incAddr  = 1'b1;
          ctl.loadRead = 1'b1;
        end
        ST_WR_ACK: begin
          stateNext   = ST_WR;
          cntNext     = 4'd8;
          ctl.incAddr = 1'b1;
        end
        default: ;
      endcase
    end else if (sclFall) begin
      unique case (state)
        ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_RD_ACK, ST_WR_ACK: ctl.drvLow = 1'b1;
        ST_RD:   ctl.drvBit  = 1'b1;
        default: ctl.relLine = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= cntNext;
    end
  end

endmodule

// File: rtl/twi_eeprom_dp.sv
module twi_eeprom_dp
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES = 512
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  output logic   latchLsb,
  output logic   sdaSlave
);

  localparam int AW = $clog2(MEM_BYTES);

  logic [7:0]    latch, latchShift;
  logic [AW-1:0] addr, addrNext, devAddr;
  logic [7:0]    mem [MEM_BYTES];

  assign latchShift = {latch[6:0], ctl.bitIn};
  assign latchLsb   = latch[0];

  // address taken from the device byte, by size class
  generate
    if (MEM_BYTES < 256) begin : g_small
      assign devAddr = AW'(latch >> 1);
    end else if (MEM_BYTES < 4096) begin : g_mid
      assign devAddr = AW'({latch[3:1], 8'd0});
    end else begin : g_large
      assign devAddr = '0;
    end
  endgenerate

  always_comb begin
    if (ctl.setAddrDev)      addrNext = devAddr;
    else if (ctl.loadAddrHi) addrNext = AW'({latchShift, 8'd0});
    else if (ctl.orAddrLo)   addrNext = addr | AW'(latchShift);
    else if (ctl.incAddr)    addrNext = addr + AW'(1);
    else                     addrNext = addr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latch    <= '0;
      addr     <= '0;
      sdaSlave <= 1'b1;
    end else begin
      addr <= addrNext;
      if (ctl.shiftIn)       latch <= latchShift;
      else if (ctl.loadRead) latch <= mem[addrNext];
      else if (ctl.drvBit)   latch <= {latch[6:0], 1'b0};
      if (ctl.relLine)     sdaSlave <= 1'b1;
      else if (ctl.drvLow) sdaSlave <= 1'b0;
      else if (ctl.drvBit) sdaSlave <= latch[7];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.memWrite) mem[addr] <= latchShift;
  end

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES = 512
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaHostIn,
  output logic sdaSlaveOut,
  output logic sdaBusOut
);

  dpCtl_t     ctl;
  busState_e  state;
  logic [3:0] bitCnt;
  logic       latchLsb;

  twi_eeprom_ctrl #(.MEM_BYTES(MEM_BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaHostIn),
    .latchLsb(latchLsb),
    .ctl     (ctl),
    .state   (state),
    .bitCnt  (bitCnt)
  );

  twi_eeprom_dp #(.MEM_BYTES(MEM_BYTES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .latchLsb(latchLsb),
    .sdaSlave(sdaSlaveOut)
  );

  assign sdaBusOut = sdaHostIn & sdaSlaveOut;

endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk
  import twi_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input busState_e  state,
  input logic [3:0] bitCnt,
  input logic       sdaSlaveOut
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> sdaSlaveOut); // R2

  AST_START_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && $past(state) != ST_DEV) |-> bitCnt == 4'd8); // R1

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8); // R3

  AST_ACK_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV_ACK && $past(state) == ST_DEV) |-> $past(bitCnt) == 4'd1); // R3

  AST_DRIVE_LOW_SCOPE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaSlaveOut) |-> (state == ST_RD || state == ST_DEV_ACK || state == ST_AHI_ACK ||
                            state == ST_ALO_ACK || state == ST_RD_ACK || state == ST_WR_ACK)); // R4

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD && $past(state) == ST_RD) |->
      (bitCnt == $past(bitCnt) || bitCnt == $past(bitCnt) - 4'd1)); // R4

endmodule

bind twi_eeprom twi_eeprom_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .state      (state),
  .bitCnt     (bitCnt),
  .sdaSlaveOut(sdaSlaveOut)
);

// File: tb/twi_eeprom_bench.sv
module twi_eeprom_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PH = 6;
  localparam int SZ0 = 128;
  localparam int SZ1 = 1024;
  localparam int SZ2 = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] scl = 3'b111;
  logic [2:0] sdaH = 3'b111;
  wire  [2:0] sdaS, sdaB;

  int nChecks = 0;
  int nFails = 0;
  int sel = 0;
  logic [7:0] refMem [3][4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : g_dut
    localparam int S = (g == 0) ? SZ0 : (g == 1) ? SZ1 : SZ2;
    twi_eeprom #(.MEM_BYTES(S)) u_twi_eeprom (
      .clk        (clk),
      .rstN       (rstN),
      .sclIn      (scl[g]),
      .sdaHostIn  (sdaH[g]),
      .sdaSlaveOut(sdaS[g]),
      .sdaBusOut  (sdaB[g])
    );
  end

  function automatic int sizeOf(input int s);
    return (s == 0) ? SZ0 : (s == 1) ? SZ1 : SZ2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitPh();
    repeat (PH) @(negedge clk);
  endtask

  task automatic setScl(input logic v);
    scl[sel] = v;
    waitPh();
  endtask

  task automatic setSda(input logic v);
    sdaH[sel] = v;
    waitPh();
  endtask

  task automatic busStart();
    setSda(1'b1); setScl(1'b1); setSda(1'b0); setScl(1'b0);
  endtask

  task automatic busStop();
    setSda(1'b0); setScl(1'b1); setSda(1'b1);
  endtask

  task automatic putBit(input logic b);
    setSda(b); setScl(1'b1); setScl(1'b0);
  endtask

  task automatic putByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    setSda(1'b1);
    setScl(1'b1);
    ack = sdaB[sel];
    setScl(1'b0);
  endtask

  task automatic getByte(output logic [7:0] d);
    setSda(1'b1);
    for (int i = 7; i >= 0; i--) begin
      setScl(1'b1);
      d[i] = sdaB[sel];
      setScl(1'b0);
    end
    setScl(1'b1);
    setScl(1'b0);
  endtask

  // size class encodes address in the device byte differently
  function automatic logic [7:0] devByte(input int a, input logic rd);
    logic [15:0] w = 16'(a);
    if (sel == 0)      return {w[6:0], rd};
    else if (sel == 1) return {4'hA, w[10:8], rd};
    else               return {7'b1010000, rd};
  endfunction

  task automatic sendHeader(input int a, input string tag);
    logic ack;
    logic [15:0] w = 16'(a);
    busStart();
    putByte(devByte(a, 1'b0), ack);
    chk(ack == 1'b0, {"R5 write device ack ", tag}, int'(ack), 0);
    if (sel == 2) begin
      putByte(w[15:8], ack);
      chk(ack == 1'b0, "R8 high address ack", int'(ack), 0);
    end
    if (sel != 0) begin
      putByte(w[7:0], ack);
      chk(ack == 1'b0, {"R7 R8 low address ack ", tag}, int'(ack), 0);
    end
  endtask

  task automatic writeBurst(input int a, input int n, input int seed, input string tag);
    logic ack;
    logic [7:0] d;
    sendHeader(a, tag);
    for (int k = 0; k < n; k++) begin
      d = 8'(seed + k * 37);
      putByte(d, ack);
      chk(ack == 1'b0, {"R3 data ack ", tag}, int'(ack), 0);
      refMem[sel][(a + k) % sizeOf(sel)] = d;
    end
    busStop();
  endtask

  task automatic readBurst(input int a, input int n, input string tag);
    logic ack;
    logic [7:0] d, e;
    if (sel == 0) begin
      busStart();
      putByte(devByte(a, 1'b1), ack);
    end else begin
      sendHeader(a, tag);
      busStart();
      putByte(devByte(0, 1'b1), ack);
    end
    chk(ack == 1'b0, {"R5 read device ack ", tag}, int'(ack), 0);
    for (int k = 0; k < n; k++) begin
      getByte(d);
      e = refMem[sel][(a + k) % sizeOf(sel)];
      chk(d == e, {"R4 R9 read data ", tag}, int'(d), int'(e));
    end
    busStop();
  endtask

  task automatic testReset();
    for (int s = 0; s < 3; s++)
      chk(sdaB[s] == 1'b1 && sdaS[s] == 1'b1, "R10 released after reset", int'(sdaB[s]), 1);
  endtask

  task automatic testWiredAnd();
    sel = 0;
    setScl(1'b0);
    setSda(1'b0);
    chk(sdaB[0] == 1'b0, "R10 host low wins", int'(sdaB[0]), 0);
    chk(sdaS[0] == 1'b1, "R10 slave still released", int'(sdaS[0]), 1);
    setSda(1'b1);
    chk(sdaB[0] == 1'b1, "R10 both released", int'(sdaB[0]), 1);
    setScl(1'b1);
  endtask

  task automatic testSmall();
    sel = 0;
    writeBurst(32, 4, 8'h11, "R6 small");
    readBurst(32, 4, "R6 small");
    writeBurst(126, 4, 8'h5A, "R9 small wrap");
    readBurst(126, 4, "R9 small wrap");
  endtask

  task automatic testIdleIgnore();
    logic ack;
    logic [7:0] e;
    sel = 0;
    writeBurst(5, 1, 8'hC3, "R2 setup");
    setScl(1'b0);
    putByte(devByte(5, 1'b0), ack);
    chk(ack == 1'b1, "R2 no ack while idle", int'(ack), 1);
    putByte(8'h00, ack);
    chk(ack == 1'b1, "R2 no ack while idle", int'(ack), 1);
    setScl(1'b1);
    e = refMem[0][5];
    readBurst(5, 1, "R2 memory untouched");
    chk(e == 8'hC3, "R2 reference kept", int'(e), 8'hC3);
  endtask

  task automatic testRestart();
    logic ack;
    logic [7:0] d;
    sel = 0;
    writeBurst(34, 1, 8'h77, "R1 setup");
    busStart();
    putBit(1'b1); putBit(1'b0); putBit(1'b1);
    busStart();
    putByte(devByte(34, 1'b1), ack);
    chk(ack == 1'b0, "R1 ack after restart", int'(ack), 0);
    getByte(d);
    chk(d == refMem[0][34], "R1 data after restart", int'(d), int'(refMem[0][34]));
    busStop();
  endtask

  task automatic testMid();
    sel = 1;
    writeBurst(12'h3F0, 3, 8'h21, "R7 mid");
    writeBurst(12'h1F0, 3, 8'h90, "R7 mid");
    readBurst(12'h3F0, 3, "R7 mid upper bits");
    readBurst(12'h1F0, 3, "R7 mid upper bits");
    writeBurst(1022, 3, 8'h44, "R9 mid wrap");
    readBurst(1022, 3, "R9 mid wrap");
  endtask

  task automatic testLarge();
    sel = 2;
    writeBurst(12'hABC, 4, 8'h31, "R8 large");
    writeBurst(12'h5BC, 4, 8'hE0, "R8 large");
    readBurst(12'hABC, 4, "R8 high byte");
    readBurst(12'h5BC, 4, "R8 high byte");
    writeBurst(4094, 3, 8'h66, "R9 large wrap");
    readBurst(4094, 3, "R9 large wrap");
  endtask

  task automatic testRandom();
    int a;
    for (int s = 0; s < 3; s++) begin
      sel = s;
      for (int k = 0; k < 5; k++) begin
        a = int'($urandom % sizeOf(s));
        writeBurst(a, 1, int'($urandom % 256), "R9 random");
        readBurst(a, 1, "R9 random");
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWiredAnd();
    testSmall();
    testIdleIgnore();
    testRestart();
    testMid();
    testLarge();
    testRandom();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule